// File: doc/BRIEF.md
# XGMII to XAUI Transmit Code-Group Mapper

This block sits in a 10-gigabit transmit path just ahead of the 8B/10B encoders. Each clock it takes one XGMII column: four byte lanes, each with a data byte and a control flag. For every lane it produces the byte to encode and a K flag. A data byte with its control flag low goes through unchanged. Control characters become their special code groups. A control byte that has no meaning is replaced by the error code group.

A column made only of idle characters is not sent as a fixed pattern. A small idle sequencer chooses one code group for the whole column. It places an alignment code group (/A/) at spacings of 16 to 31 idle columns. Between those, a 7-bit pseudo-random sequence picks /K/ or /R/. Idle characters that share a column with other characters, such as those after a terminate, always become /K/. Results appear one clock after the column is presented.

Top module: `xaui_tx_mapper`

## Requirements
- R1: A lane with its control flag low is output with the same byte and its K flag low.
- R2: With the control flag high, byte 0x9C (sequence), 0xFB (start), 0xFD (terminate) and 0xFE (error) are output as the same byte value with the K flag high.
- R3: With the control flag high, the reserved control bytes 0x1C, 0x3C, 0x7C, 0xBC, 0xDC and 0xF7 are output unchanged with the K flag high.
- R4: Any other byte with the control flag high is invalid and is output as 0xFE with the K flag high.
- R5: A lane holding control byte 0x07, in a column where not every lane is control 0x07, is output as 0xBC (/K/) with the K flag high.
- R6: A column in which every lane is control 0x07 (an idle column) is output with the same byte on all lanes, one of 0x1C (/R/), 0x7C (/A/) or 0xBC (/K/), and every K flag high.
- R7: A 7-bit state is seeded to 0x7F at reset and steps once per idle column as next = {s[5:0], s[6] xor s[5]}. In an idle column that is not an /A/ column, the state before the step selects /K/ when s[0] is 1 and /R/ when s[0] is 0.
- R8: After reset, the first /A/ comes after exactly 16 non-/A/ idle columns. After each /A/, exactly 16 + s[3:0] non-/A/ idle columns come before the next /A/, where s is the state in the /A/ column.
- R9: Columns that are not idle leave both the pseudo-random state and the /A/ countdown unchanged.
- R10: Outputs are registered with one clock of latency. While reset (active low, synchronous) is asserted, all code bytes and K flags are 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_data | input | 32 | XGMII data, lane 0 in bits 7:0 |
| tx_ctrl | input | 4 | XGMII control flag per lane |
| pcs_code | output | 32 | Code-group byte per lane, lane 0 in bits 7:0 |
| pcs_k | output | 4 | K flag per lane |

## Verification
The assertions check three things on every cycle. Data lanes pass through with the K flag low. K flags follow the control flags one cycle later. Idle columns come out uniform across lanes with a legal idle code. They also check that the /A/ spacing never leaves the 16 to 31 window and that non-idle columns freeze the sequencer. The exact /K/ or /R/ choice and the exact /A/ positions, including what happens after an interruption or a second reset, can only be shown by the bench. The bench keeps its own model of the sequence and compares it against long idle runs that are broken up by random traffic.

// File: rtl/xaui_map_pkg.sv
// Package: shared code-group constants and the idle selection type for the
// XGMII to XAUI mapper. Assumes 8-bit pre-encoding byte values.
package xaui_map_pkg;

    localparam logic [7:0] CH_IDLE  = 8'h07;
    localparam logic [7:0] CG_R     = 8'h1C;
    localparam logic [7:0] CG_A     = 8'h7C;
    localparam logic [7:0] CG_K     = 8'hBC;
    localparam logic [7:0] CG_SEQ   = 8'h9C;
    localparam logic [7:0] CG_START = 8'hFB;
    localparam logic [7:0] CG_TERM  = 8'hFD;
    localparam logic [7:0] CG_ERR   = 8'hFE;

    typedef enum logic [1:0] {
        SEL_K = 2'd0,
        SEL_R = 2'd1,
        SEL_A = 2'd2
    } idle_sel_t;

    // Reserved control bytes that pass through unchanged
    function automatic logic is_reserved(input logic [7:0] c);
        return (c == 8'h1C) || (c == 8'h3C) || (c == 8'h7C) ||
               (c == 8'hBC) || (c == 8'hDC) || (c == 8'hF7);
    endfunction

    // Control bytes with a defined transmit meaning
    function automatic logic is_defined(input logic [7:0] c);
        return (c == CG_SEQ) || (c == CG_START) || (c == CG_TERM) || (c == CG_ERR);
    endfunction

endpackage

// File: rtl/xaui_idle_seq.sv
// Module: idle sequencer. Holds the 7-bit pseudo-random state
// (x^7 + x^6 + 1) and the /A/ countdown, and reports which idle code
// group the current idle column must carry.
// Assumes: idle_col is high only for columns made entirely of idles;
// the state steps only on such columns.
module xaui_idle_seq
    import xaui_map_pkg::*;
#(
    parameter logic [6:0] SEED      = 7'h7F,
    parameter int         A_MIN     = 16,
    parameter int         SPAN_BITS = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle_col,
    output idle_sel_t idle_sel
);
    localparam int A_MAX = A_MIN + (1 << SPAN_BITS) - 1;
    localparam int CW    = $clog2(A_MAX + 1);
    localparam int GW    = CW + 1;

    logic [6:0]    prbs_q;
    logic [CW-1:0] cnt_q;
    logic [6:0]    prbs_nxt;

    // Next pseudo-random state for the x^7 + x^6 + 1 polynomial
    assign prbs_nxt = {prbs_q[5:0], prbs_q[6] ^ prbs_q[5]};

    // Pick the code group for this idle column from countdown and state
    always_comb begin
        if (cnt_q == '0)
            idle_sel = SEL_A;
        else if (prbs_q[0])
            idle_sel = SEL_K;
        else
            idle_sel = SEL_R;
    end

    // Step state and countdown on idle columns only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prbs_q <= SEED;
            cnt_q  <= CW'(A_MIN);
        end else if (idle_col) begin
            prbs_q <= prbs_nxt;
            if (cnt_q == '0)
                cnt_q <= CW'(A_MIN) + CW'(prbs_q[SPAN_BITS-1:0]);
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Checker: count non-/A/ idle columns since the last /A/ (or reset)
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (idle_col && idle_sel == SEL_A)
            gap_q <= '0;
        else if (idle_col && gap_q != '1)
            gap_q <= gap_q + 1'b1;
    end

    AST_A_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_col && idle_sel == SEL_A) |-> (gap_q >= GW'(A_MIN))); // R8
    AST_A_GAP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GW'(A_MAX)); // R8
    AST_PRBS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        prbs_q != 7'd0); // R7
    AST_HOLD_ON_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_col |=> ($stable(prbs_q) && $stable(cnt_q))); // R9

endmodule

// File: rtl/xaui_lane_map.sv
// Module: single-lane code mapper (combinational). Turns one XGMII byte and
// its control flag into a code-group byte and K flag.
// Assumes: idle_col and idle_sel describe the whole column this lane is in.
module xaui_lane_map
    import xaui_map_pkg::*;
(
    input  logic [7:0] txd,
    input  logic       txc,
    input  logic       idle_col,
    input  idle_sel_t  idle_sel,
    output logic [7:0] code,
    output logic       is_k
);
    // Resolve the lane's output byte from its control class
    always_comb begin
        is_k = txc;
        code = txd;
        if (txc) begin
            if (txd == CH_IDLE) begin
                if (idle_col) begin
                    unique case (idle_sel)
                        SEL_A:   code = CG_A;
                        SEL_R:   code = CG_R;
                        default: code = CG_K;
                    endcase
                end else begin
                    code = CG_K;
                end
            end else if (is_defined(txd) || is_reserved(txd)) begin
                code = txd;
            end else begin
                code = CG_ERR;
            end
        end
    end
endmodule

// File: rtl/xaui_tx_mapper.sv
// Module: XGMII to XAUI transmit code-group mapper (top). Detects idle
// columns, runs the idle sequencer, maps each lane and registers the result.
// Assumes: one XGMII column per clock, lane 0 in the low byte.
module xaui_tx_mapper
    import xaui_map_pkg::*;
#(
    parameter int         LANES     = 4,
    parameter logic [6:0] SEED      = 7'h7F,
    parameter int         A_MIN     = 16,
    parameter int         SPAN_BITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES*8-1:0] tx_data,
    input  logic [LANES-1:0]   tx_ctrl,
    output logic [LANES*8-1:0] pcs_code,
    output logic [LANES-1:0]   pcs_k
);
    localparam int DW = LANES * 8;

    logic [LANES-1:0] lane_idle;
    logic             idle_col;
    idle_sel_t        idle_sel;
    logic [DW-1:0]    code_d;
    logic [LANES-1:0] k_d;

    // Column is idle only when every lane carries the idle control byte
    assign idle_col = &lane_idle;

    xaui_idle_seq #(
        .SEED      (SEED),
        .A_MIN     (A_MIN),
        .SPAN_BITS (SPAN_BITS)
    ) u_idle_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_col (idle_col),
        .idle_sel (idle_sel)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_idle[i] = tx_ctrl[i] && (tx_data[i*8 +: 8] == CH_IDLE);

        xaui_lane_map u_map (
            .txd      (tx_data[i*8 +: 8]),
            .txc      (tx_ctrl[i]),
            .idle_col (idle_col),
            .idle_sel (idle_sel),
            .code     (code_d[i*8 +: 8]),
            .is_k     (k_d[i])
        );
    end

    // Output register stage, one clock of latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcs_code <= '0;
            pcs_k    <= '0;
        end else begin
            pcs_code <= code_d;
            pcs_k    <= k_d;
        end
    end

    // Checker: marks cycles whose outputs reflect a post-reset column
    logic run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    // Checker: all lanes carry the same byte as lane 0
    logic lanes_same;
    always_comb begin
        lanes_same = 1'b1;
        for (int j = 1; j < LANES; j++)
            if (pcs_code[j*8 +: 8] != pcs_code[7:0]) lanes_same = 1'b0;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && !$past(tx_ctrl[i])) |->
            (!pcs_k[i] && pcs_code[i*8 +: 8] == $past(tx_data[i*8 +: 8]))); // R1
    end

    AST_K_FOLLOWS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (pcs_k == $past(tx_ctrl))); // R10
    AST_IDLE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(idle_col)) |->
        (lanes_same && (&pcs_k) &&
         (pcs_code[7:0] == CG_A || pcs_code[7:0] == CG_K || pcs_code[7:0] == CG_R))); // R6

endmodule

// File: tb/xaui_tx_mapper_tb.sv
`timescale 1ns/1ps
// Bench: random and directed XGMII columns checked against a reference model
// built from the requirements.
module xaui_tx_mapper_tb;
    localparam int LANES = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [LANES*8-1:0]   tx_data = '0;
    logic [LANES-1:0]     tx_ctrl = '0;
    logic [LANES*8-1:0]   pcs_code;
    logic [LANES-1:0]     pcs_k;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    logic [6:0] m_prbs;
    int         m_cnt;

    always #2.5 clk = ~clk;

    xaui_tx_mapper u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_data  (tx_data),
        .tx_ctrl  (tx_ctrl),
        .pcs_code (pcs_code),
        .pcs_k    (pcs_k)
    );

    function automatic logic reserved_b(input logic [7:0] c);
        return c == 8'h1C || c == 8'h3C || c == 8'h7C || c == 8'hBC ||
               c == 8'hDC || c == 8'hF7;
    endfunction

    function automatic logic defined_b(input logic [7:0] c);
        return c == 8'h9C || c == 8'hFB || c == 8'hFD || c == 8'hFE;
    endfunction

    task automatic model_reset();
        m_prbs = 7'h7F;
        m_cnt  = 16;
    endtask

    task automatic check(input bit ok, input string tag, input string ctx,
                         input int lane, input logic [8:0] act, input logic [8:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s%s lane %0d: got k=%b code=%h expected k=%b code=%h",
                     tag, ctx, lane, act[8], act[7:0], exp_v[8], exp_v[7:0]);
        end
    endtask

    // Drive one column, advance the model, check one edge later (R10 latency)
    task automatic step(input logic [31:0] d, input logic [3:0] c, input string ctx);
        logic       idle;
        logic [7:0] idle_code;
        string      itag;
        logic [8:0] exp_l [LANES];
        string      tag_l [LANES];
        idle = 1'b1;
        for (int i = 0; i < LANES; i++)
            if (!(c[i] && d[i*8 +: 8] == 8'h07)) idle = 1'b0;
        idle_code = 8'hBC;
        itag = "R7";
        if (idle) begin
            if (m_cnt == 0) begin
                idle_code = 8'h7C; itag = "R8";
                m_cnt = 16 + int'(m_prbs[3:0]);
            end else begin
                idle_code = m_prbs[0] ? 8'hBC : 8'h1C;
                m_cnt--;
            end
            m_prbs = {m_prbs[5:0], m_prbs[6] ^ m_prbs[5]};
        end
        for (int i = 0; i < LANES; i++) begin
            logic [7:0] b;
            b = d[i*8 +: 8];
            if (!c[i])                 begin exp_l[i] = {1'b0, b};        tag_l[i] = "R1"; end
            else if (b == 8'h07 && idle) begin exp_l[i] = {1'b1, idle_code}; tag_l[i] = itag; end
            else if (b == 8'h07)       begin exp_l[i] = {1'b1, 8'hBC};    tag_l[i] = "R5"; end
            else if (defined_b(b))     begin exp_l[i] = {1'b1, b};        tag_l[i] = "R2"; end
            else if (reserved_b(b))    begin exp_l[i] = {1'b1, b};        tag_l[i] = "R3"; end
            else                       begin exp_l[i] = {1'b1, 8'hFE};    tag_l[i] = "R4"; end
        end
        tx_data = d;
        tx_ctrl = c;
        @(posedge clk);
        #1;
        for (int i = 0; i < LANES; i++)
            check({pcs_k[i], pcs_code[i*8 +: 8]} == exp_l[i], tag_l[i], ctx, i,
                  {pcs_k[i], pcs_code[i*8 +: 8]}, exp_l[i]);
        if (idle)
            check(pcs_code == {4{pcs_code[7:0]}} && pcs_k == 4'hF, "R6", ctx, 0,
                  {pcs_k[0], pcs_code[7:0]}, {1'b1, idle_code});
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tx_data = 32'hDEADBEEF;
        tx_ctrl = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < LANES; i++)
            check(pcs_code[i*8 +: 8] == 8'h00 && !pcs_k[i], "R10", " reset", i,
                  {pcs_k[i], pcs_code[i*8 +: 8]}, 9'h000);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    localparam logic [31:0] IDLE_D = 32'h07070707;

    initial begin
        void'($urandom(32'd20241));
        do_reset();
        // Directed: data, defined controls, reserved, invalid, terminate column
        step(32'h00FF5AA5, 4'h0, " data");
        step(32'hFEFDFB9C, 4'hF, " controls");
        step(32'hDC7C3C1C, 4'hF, " reserved lo");
        step(32'h55F7BC00, 4'h7, " reserved hi");
        step(32'h5507AB00, 4'hF, " invalid");
        step(32'h070707FD, 4'hF, " after terminate");
        step(32'h07070707, 4'h7, " partial idle");
        // Long idle run covers first /A/ at 16 and later spacing
        for (int n = 0; n < 120; n++) step(IDLE_D, 4'hF, " idle run");
        // Interruption in mid-run must not disturb the sequence (R9)
        for (int n = 0; n < 10; n++) step(IDLE_D, 4'hF, " R9 pre");
        for (int n = 0; n < 5; n++) step($urandom, 4'h0, " R9 gap");
        for (int n = 0; n < 60; n++) step(IDLE_D, 4'hF, " R9 post");
        // Mid-run reset restarts the sequence (R10, R8)
        do_reset();
        for (int n = 0; n < 40; n++) step(IDLE_D, 4'hF, " after reset");
        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [31:0] d;
            logic [3:0]  c;
            r = $urandom_range(0, 9);
            d = $urandom;
            c = 4'($urandom);
            if (r < 5) begin d = IDLE_D; c = 4'hF; end
            else if (r == 5) c = 4'h0;
            else if (r == 6) begin d = 32'h070707FD; c = 4'hF; end
            else if (r == 7) begin
                for (int i = 0; i < LANES; i++) begin
                    logic [7:0] pick [8];
                    pick = '{8'h9C, 8'hFB, 8'hFD, 8'hFE, 8'h1C, 8'hDC, 8'hF7, 8'h07};
                    d[i*8 +: 8] = pick[$urandom_range(0, 7)];
                end
                c = 4'hF;
            end
            step(d, c, " random");
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule